// File: doc/BRIEF.md
# Register File with Display Color Port

This block holds the working registers of a small 8-bit processor: eight 8-bit entries, two read ports that answer combinationally and one write port that commits on the rising clock edge. Entry 0 is a constant zero. Any value written to it is thrown away, so code can use it as a zero source or as a write sink.

Entry 7 is also a live color register. Its six low bits are split into three 2-bit channels, red, green and blue, and sent to a display connector. When the external display-active input is low, all color bits are forced to zero, so no color reaches the screen during blanking. The top two bits of entry 7 are plain storage. The block also places the six color bits and the two sync inputs into one output byte with a fixed bit order for the connector.

Top module: `gpr_colorport`

## Requirements
- R1: Reading address 0 on either read port always gives 0x00.
- R2: A write with address 0 is discarded. No register changes, and address 0 still reads 0x00.
- R3: A write to addresses 1 to 7 appears on a read port in the cycle after the clock edge that commits it. In the cycle of the write, the read port still shows the old value.
- R4: The two read ports select independently. Each one returns the register named by its own address in the same cycle.
- R5: While `rstN` is low at a rising clock edge, every register is cleared to 0x00.
- R6: While `displayOn` is high, the color bits of `pinByte` follow register 7. Register 7 bits [5:4] are red[1:0], bits [3:2] are green[1:0] and bits [1:0] are blue[1:0]. The pin byte order is: bit0 red[1], bit1 green[1], bit2 blue[1], bit4 red[0], bit5 green[0], bit6 blue[0].
- R7: While `displayOn` is low, `pinByte` bits 0, 1, 2, 4, 5 and 6 are all 0, whatever register 7 holds.
- R8: Register 7 bits [7:6] are stored and read back normally, but they have no effect on `pinByte`.
- R9: `pinByte` bit 7 always equals `hSync` and bit 3 always equals `vSync`, whether `displayOn` is high or low.
- R10: A write to one register leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 3 | Write register address |
| wrData | input | 8 | Write data |
| rdAddrA | input | 3 | Read port A address |
| rdAddrB | input | 3 | Read port B address |
| displayOn | input | 1 | High while the beam is in the visible area |
| hSync | input | 1 | Horizontal sync, passed to the pin byte |
| vSync | input | 1 | Vertical sync, passed to the pin byte |
| rdDataA | output | 8 | Read port A data |
| rdDataB | output | 8 | Read port B data |
| pinByte | output | 8 | Packed color and sync byte for the connector |

## Verification
The bench writes to address 0 and then reads it on both ports. A design that stores into entry 0 would return the written value. It also reads a register in the same cycle it is written. A design that bypasses write data to the read port would show the new value one cycle early. Register 7 is loaded with a different bit pattern in each color channel, so a swapped channel or a shifted pin position shows up as a wrong bit in `pinByte`. Register 7 is also loaded with only its top two bits set and then with those bits flipped while the color bits stay fixed. This catches a design that lets bits [7:6] reach the color pins or that drops their storage. Blanking is toggled while both sync inputs are held high. A design that also gates the sync bits during blanking, or that fails to blank the color bits, gives a wrong byte.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int REG_NUM   = 8;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = $clog2(REG_NUM);
  localparam int COLOR_REG = REG_NUM - 1;
  localparam int CH_W      = 2;
  localparam int COLOR_W   = 3 * CH_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic [REG_NUM-1:0] load;   // one-hot write strobe per entry
    logic               blank;  // force color bits to zero
  } ctrlStrobe_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              displayOn,
  output ctrlStrobe_t       strobes
);
  always_comb begin
    strobes.load = '0;
    for (int i = 1; i < REG_NUM; i++) begin
      strobes.load[i] = wrEn && (wrAddr == ADDR_W'(i));
    end
    strobes.blank = !displayOn;
  end
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              hSync,
  input  logic              vSync,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [7:0]        pinByte
);
  logic [REG_NUM-1:0][DATA_W-1:0] regQ;

  generate
    for (genvar i = 0; i < REG_NUM; i++) begin : g_entry
      if (i == 0) begin : g_zero
        assign regQ[i] = '0;
      end else begin : g_store
        always_ff @(posedge clk) begin
          if (!rstN)                regQ[i] <= '0;
          else if (strobes.load[i]) regQ[i] <= wrData;
        end
      end
    end
  endgenerate

  assign rdDataA = regQ[rdAddrA];
  assign rdDataB = regQ[rdAddrB];

  logic [COLOR_W-1:0] colorBits;
  logic [CH_W-1:0]    red, green, blue;

  assign colorBits = strobes.blank ? '0 : regQ[COLOR_REG][COLOR_W-1:0];
  assign red   = colorBits[3*CH_W-1:2*CH_W];
  assign green = colorBits[2*CH_W-1:CH_W];
  assign blue  = colorBits[CH_W-1:0];

  // Connector bit order is fixed
  assign pinByte = {hSync, blue[0], green[0], red[0],
                    vSync, blue[1], green[1], red[1]};
endmodule

// File: rtl/gpr_colorport.sv
module gpr_colorport
  import regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              displayOn,
  input  logic              hSync,
  input  logic              vSync,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [7:0]        pinByte
);
  ctrlStrobe_t strobes;

  regfile_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .displayOn (displayOn),
    .strobes   (strobes)
  );

  regfile_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .hSync   (hSync),
    .vSync   (vSync),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB),
    .pinByte (pinByte)
  );
endmodule

// File: rtl/gpr_colorport_checker.sv
module gpr_colorport_checker
  import regfile_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic              displayOn,
  input logic              hSync,
  input logic              vSync,
  input logic [DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0] rdDataB,
  input logic [7:0]        pinByte
);
  assert_zero_reads_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0) |-> (rdDataA == '0));

  assert_zero_readb_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrB == '0) |-> (rdDataB == '0));

  assert_write_next_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0) |=>
      (rdAddrA != $past(wrAddr) || rdDataA == $past(wrData)));

  assert_reset_clears_R5: assert property (@(posedge clk)
    (!rstN) |=> (rdDataA == '0 && rdDataB == '0));

  assert_blank_color_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!displayOn) |-> (pinByte[2:0] == 3'b000 && pinByte[6:4] == 3'b000));

  assert_color_map_R6: assert property (@(posedge clk) disable iff (!rstN)
    (displayOn && rdAddrB == ADDR_W'(COLOR_REG)) |->
      (pinByte[0] == rdDataB[5] && pinByte[4] == rdDataB[4] &&
       pinByte[1] == rdDataB[3] && pinByte[5] == rdDataB[2] &&
       pinByte[2] == rdDataB[1] && pinByte[6] == rdDataB[0]));

  assert_sync_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pinByte[7] == hSync && pinByte[3] == vSync));
endmodule

bind gpr_colorport gpr_colorport_checker u_checker (.*);

// File: tb/gpr_colorport_bench.sv
module gpr_colorport_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddrA = '0;
  logic [2:0] rdAddrB = '0;
  logic       displayOn = 1'b0;
  logic       hSync = 1'b0;
  logic       vSync = 1'b0;
  logic [7:0] rdDataA, rdDataB, pinByte;

  always #10 clk = ~clk;  // 50 MHz

  gpr_colorport u_gpr_colorport (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] mdl [8];

  // scoreboard queues: 0 = port A, 1 = port B, 2 = pin byte
  int         portQ[$];
  logic [7:0] expQ[$];
  string      tagQ[$];
  event       sampleEv;

  function automatic logic [7:0] packPins(logic [7:0] r7, logic disp, logic hs, logic vs);
    logic [5:0] c;
    c = disp ? r7[5:0] : 6'd0;
    return {hs, c[0], c[2], c[4], vs, c[1], c[3], c[5]};
  endfunction

  task automatic expectItem(int port, logic [7:0] val, string tag);
    portQ.push_back(port);
    expQ.push_back(val);
    tagQ.push_back(tag);
  endtask

  initial begin
    forever begin
      @(sampleEv);
      while (portQ.size() > 0) begin
        int p;
        logic [7:0] e, act;
        string t;
        p = portQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        act = (p == 0) ? rdDataA : (p == 1) ? rdDataB : pinByte;
        checks++;
        if (act !== e) begin
          failures++;
          $display("FAIL %s port%0d actual=%02h expected=%02h", t, p, act, e);
        end
      end
    end
  end

  task automatic readPair(logic [2:0] a, logic [2:0] b, string tag);
    @(negedge clk);
    wrEn = 0;
    rdAddrA = a;
    rdAddrB = b;
    #2;
    expectItem(0, mdl[a], tag);
    expectItem(1, mdl[b], tag);
    -> sampleEv;
  endtask

  // write; check port A shows old value during the write cycle (R3)
  task automatic writeReg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1;
    wrAddr = a;
    wrData = d;
    rdAddrA = a;
    #2;
    expectItem(0, mdl[a], "R3 same-cycle old value");
    -> sampleEv;
    @(posedge clk);
    if (a != 0) mdl[a] = d;
    #1;
    @(negedge clk);
    wrEn = 0;
    #2;
    expectItem(0, mdl[a], "R3 next-cycle new value");
    -> sampleEv;
  endtask

  task automatic checkPins(logic disp, logic hs, logic vs, string tag);
    @(negedge clk);
    displayOn = disp;
    hSync = hs;
    vSync = vs;
    #2;
    expectItem(2, packPins(mdl[7], disp, hs, vs), tag);
    -> sampleEv;
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    // dirty the registers first, then reset (R5)
    repeat (2) @(posedge clk);
    rstN = 1;
    for (int i = 1; i < 8; i++) writeReg(3'(i), 8'hA0 + 8'(i));
    @(negedge clk);
    rstN = 0;
    @(posedge clk);
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    @(negedge clk);
    rstN = 1;
    for (int i = 0; i < 8; i += 2) readPair(3'(i), 3'(i + 1), "R5 reset clears");

    // R1 / R2: write to r0 discarded
    writeReg(3'd0, 8'hFF);
    readPair(3'd0, 3'd0, "R1 R2 zero reads");

    // R3 / R10: fill with distinct patterns, check no disturbance
    for (int i = 1; i < 8; i++) writeReg(3'(i), 8'h11 * 8'(i));
    for (int i = 0; i < 8; i++) readPair(3'(i), 3'(7 - i), "R4 R10 independent ports");
    writeReg(3'd3, 8'h5A);
    readPair(3'd2, 3'd4, "R10 neighbours intact");
    readPair(3'd3, 3'd0, "R4 R1 mixed ports");

    // R6 color mapping, per-channel patterns
    writeReg(3'd7, 8'b00_10_01_11);
    checkPins(1, 0, 0, "R6 mapping a");
    writeReg(3'd7, 8'b00_01_11_10);
    checkPins(1, 1, 0, "R6 mapping b");
    writeReg(3'd7, 8'b00_11_10_01);
    checkPins(1, 0, 1, "R6 mapping c");

    // R8: top bits stored, no color effect
    writeReg(3'd7, 8'b11_00_00_00);
    checkPins(1, 0, 0, "R8 top bits no color");
    readPair(3'd7, 3'd7, "R8 top bits stored");
    writeReg(3'd7, 8'b01_10_11_01);
    checkPins(1, 0, 0, "R8 top bits a");
    writeReg(3'd7, 8'b10_10_11_01);
    checkPins(1, 0, 0, "R8 top bits b");

    // R7 blanking, R9 sync pass-through
    writeReg(3'd7, 8'hFF);
    checkPins(0, 1, 1, "R7 R9 blank with syncs high");
    checkPins(1, 1, 1, "R6 R9 visible all on");
    checkPins(0, 0, 1, "R7 R9 blank vsync only");
    checkPins(0, 1, 0, "R7 R9 blank hsync only");
    readPair(3'd7, 3'd1, "R7 blank keeps r7");

    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule